// File: doc/BRIEF.md
# Interlocked Read Handshake Link

This block carries one read transfer at a time between a requesting device and a memory over a single shared set of lines that carries first the address and then the returned word. Three control lines pace the exchange: a request line raised by the device, a data-ready line raised by the memory, and an acknowledge line that each side raises in turn to answer the other. Every control edge waits for the other side's answering edge, so the exchange runs at the pace of the slower party and needs no common clock.

Each side is a clocked state machine in its own clock domain. Every control line that crosses from one side to the other passes through a synchronizer chain of at least two flops before the receiving machine acts on it. The device side accepts a read command with an address, reports busy until the exchange is over, and then returns the word together with a one-cycle done pulse. The memory side holds a read-only word store with a configurable access latency. The shared lines are modelled as two enable/value pairs combined by a multiplexer rather than as tristate pads.

Top module: `hsk_read_link`

## Requirements
- R1: After reset, the request, data-ready and acknowledge lines are low, neither side drives the shared lines (the shared value reads zero), and busy is low.
- R2: A read command accepted while idle makes the device drive the address (zero-extended) onto the shared lines and raise the request line in the same cycle, and busy goes high in that cycle.
- R3: The memory captures the address and raises acknowledge only after it has seen the request. The device stops driving the shared lines when it drops the request, and it drops the request only after it has seen acknowledge.
- R4: The request stays high until acknowledge has been seen. The memory keeps its acknowledge high until it has seen the request go low.
- R5: After the access latency, the memory drives the read word and raises data-ready together. Data-ready stays high until the device's acknowledge has been seen, and it is never high while the request is high.
- R6: On seeing data-ready, the device latches the word and raises acknowledge. After it sees data-ready fall, it drops acknowledge and pulses done for exactly one cycle, with the word on the read-data output.
- R7: The word stored at address a equals (a * CONTENT_MUL + CONTENT_ADD) mod 2^DW. The defaults are CONTENT_MUL = 0x9E37, CONTENT_ADD = 0x5A5A and DW = 16.
- R8: A read command raised while busy is ignored. It starts no second exchange and produces no done pulse, and the exchange already under way returns the word for its own address.
- R9: The device and the memory never drive the shared lines at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dev_clk | input | 1 | Device side clock |
| dev_rst_n | input | 1 | Device side active-low reset |
| mem_clk | input | 1 | Memory side clock |
| mem_rst_n | input | 1 | Memory side active-low reset |
| rd_start | input | 1 | Read command, taken when not busy |
| rd_addr | input | AW | Address of the read command |
| rd_busy | output | 1 | Exchange in progress |
| rd_done | output | 1 | One-cycle pulse at completion |
| rd_data | output | DW | Word returned by the last read |
| bus_data | output | DW | Resolved value of the shared lines |
| bus_dev_oe | output | 1 | Device is driving the shared lines |
| bus_mem_oe | output | 1 | Memory is driving the shared lines |
| ln_req | output | 1 | Request control line |
| ln_rdy | output | 1 | Data-ready control line |
| ln_ack | output | 1 | Acknowledge control line (either side) |

## Verification
The bench reads from the first and last addresses and from a scattered set in between, so it catches an address that is truncated or shifted on capture and returns the wrong word. It checks the release ordering on every sample: a memory that drives its word before the device has let go shows up as both drivers enabled, and a device that drops the request before acknowledge, or a memory that drops data-ready early, shows up as a broken interlock. A second command raised halfway through an exchange must leave a single done pulse carrying the first address's word. A design that queued or restarted on that command would produce an extra pulse or the wrong word. A done pulse that lasts two cycles is also reported.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   typedef enum logic [1:0] {
      D_IDLE = 2'd0,
      D_ADDR = 2'd1,
      D_WAIT = 2'd2,
      D_ACKD = 2'd3
   } dev_state_t;

   typedef enum logic [2:0] {
      M_IDLE = 3'd0,
      M_ACK  = 3'd1,
      M_ACC  = 3'd2,
      M_RDY  = 3'd3,
      M_TAIL = 3'd4
   } mem_state_t;

   // Stored word for an address: a*mul + add, truncated by the caller.
   function automatic logic [63:0] hsk_word(input logic [63:0] a,
                                            input logic [63:0] mul,
                                            input logic [63:0] add);
      return a * mul + add;
   endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsk_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hsk_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hsk_mem_model.sv
module hsk_mem_model
   import hsk_pkg::*;
#(
   parameter int          AW          = 4,
   parameter int          DW          = 16,
   parameter int          LAT         = 4,
   parameter int unsigned CONTENT_MUL = 'h9E37,
   parameter int unsigned CONTENT_ADD = 'h5A5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_valid,
   output logic [DW-1:0] rd_word
);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("hsk_mem_model: LAT must be at least 1");
      end
   endgenerate

   logic [DW-1:0] word_now;
   assign word_now = DW'(hsk_word(64'(rd_addr), 64'(CONTENT_MUL), 64'(CONTENT_ADD)));

   generate
      if (LAT == 1) begin : g_single
         logic          v_q;
         logic [DW-1:0] d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else begin
               v_q <= rd_en;
               d_q <= word_now;
            end
         end
         assign rd_valid = v_q;
         assign rd_word  = d_q;
      end else begin : g_pipe
         logic [LAT-1:0]         v_q;
         logic [LAT-1:0][DW-1:0] d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= '0;
               d_q <= '0;
            end else begin
               v_q <= {v_q[LAT-2:0], rd_en};
               d_q <= {d_q[LAT-2:0], word_now};
            end
         end
         assign rd_valid = v_q[LAT-1];
         assign rd_word  = d_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/hsk_dev_side.sv
module hsk_dev_side
   import hsk_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] addr,
   input  logic          ack_in,
   input  logic          rdy_in,
   input  logic [DW-1:0] bus_in,
   output logic          req,
   output logic          ack_out,
   output logic          oe,
   output logic [DW-1:0] dq,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] data
);

   dev_state_t st;
   logic       ack_s;
   logic       rdy_s;

   hsk_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ack_in, rdy_in}),
      .q    ({ack_s, rdy_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= D_IDLE;
         req     <= 1'b0;
         ack_out <= 1'b0;
         oe      <= 1'b0;
         dq      <= '0;
         done    <= 1'b0;
         data    <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            D_IDLE: begin
               if (start && !ack_s && !rdy_s) begin
                  dq  <= DW'(addr);
                  oe  <= 1'b1;
                  req <= 1'b1;
                  st  <= D_ADDR;
               end
            end
            D_ADDR: begin
               if (ack_s) begin
                  oe  <= 1'b0;
                  dq  <= '0;
                  req <= 1'b0;
                  st  <= D_WAIT;
               end
            end
            D_WAIT: begin
               if (rdy_s) begin
                  data    <= bus_in;
                  ack_out <= 1'b1;
                  st      <= D_ACKD;
               end
            end
            D_ACKD: begin
               if (!rdy_s) begin
                  ack_out <= 1'b0;
                  done    <= 1'b1;
                  st      <= D_IDLE;
               end
            end
            default: st <= D_IDLE;
         endcase
      end
   end

   assign busy = (st != D_IDLE);

   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack_s |=> req);
   a_r3_req_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> $past(ack_s));
   a_r3_oe_only_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> req);
   a_r6_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out && rdy_s |=> ack_out);
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> !$past(busy));

endmodule

// File: rtl/hsk_mem_side.sv
module hsk_mem_side
   import hsk_pkg::*;
#(
   parameter int          AW          = 4,
   parameter int          DW          = 16,
   parameter int          MEM_LAT     = 4,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned CONTENT_MUL = 'h9E37,
   parameter int unsigned CONTENT_ADD = 'h5A5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_in,
   input  logic          ack_in,
   input  logic [DW-1:0] bus_in,
   output logic          ack_out,
   output logic          rdy,
   output logic          oe,
   output logic [DW-1:0] dq
);

   mem_state_t    st;
   logic          req_s;
   logic          ack_s;
   logic [AW-1:0] addr_q;
   logic          rd_en;
   logic          rd_valid;
   logic [DW-1:0] rd_word;

   hsk_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({req_in, ack_in}),
      .q    ({req_s, ack_s})
   );

   hsk_mem_model #(
      .AW         (AW),
      .DW         (DW),
      .LAT        (MEM_LAT),
      .CONTENT_MUL(CONTENT_MUL),
      .CONTENT_ADD(CONTENT_ADD)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (addr_q),
      .rd_valid(rd_valid),
      .rd_word (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= M_IDLE;
         ack_out <= 1'b0;
         rdy     <= 1'b0;
         oe      <= 1'b0;
         dq      <= '0;
         addr_q  <= '0;
         rd_en   <= 1'b0;
      end else begin
         rd_en <= 1'b0;
         case (st)
            M_IDLE: begin
               if (req_s) begin
                  addr_q  <= bus_in[AW-1:0];
                  ack_out <= 1'b1;
                  st      <= M_ACK;
               end
            end
            M_ACK: begin
               if (!req_s) begin
                  ack_out <= 1'b0;
                  rd_en   <= 1'b1;
                  st      <= M_ACC;
               end
            end
            M_ACC: begin
               if (rd_valid) begin
                  dq  <= rd_word;
                  oe  <= 1'b1;
                  rdy <= 1'b1;
                  st  <= M_RDY;
               end
            end
            M_RDY: begin
               if (ack_s) begin
                  oe  <= 1'b0;
                  dq  <= '0;
                  rdy <= 1'b0;
                  st  <= M_TAIL;
               end
            end
            M_TAIL: begin
               if (!ack_s) st <= M_IDLE;
            end
            default: st <= M_IDLE;
         endcase
      end
   end

   generate
      if (DW > AW) begin : g_upper_chk
         a_r2_addr_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
            (st == M_IDLE) && req_s |-> (bus_in[DW-1:AW] == '0));
      end
   endgenerate

   a_r3_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_out) |-> $past(req_s));
   a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out && req_s |=> ack_out);
   a_r5_rdy_held: assert property (@(posedge clk) disable iff (!rst_n)
      rdy && !ack_s |=> rdy);
   a_r5_rdy_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> oe);
   a_r5_rdy_no_own_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |-> !ack_out);

endmodule

// File: rtl/hsk_read_link.sv
module hsk_read_link #(
   parameter int          AW          = 4,
   parameter int          DW          = 16,
   parameter int          MEM_LAT     = 4,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned CONTENT_MUL = 'h9E37,
   parameter int unsigned CONTENT_ADD = 'h5A5A
) (
   input  logic          dev_clk,
   input  logic          dev_rst_n,
   input  logic          mem_clk,
   input  logic          mem_rst_n,
   input  logic          rd_start,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_busy,
   output logic          rd_done,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] bus_data,
   output logic          bus_dev_oe,
   output logic          bus_mem_oe,
   output logic          ln_req,
   output logic          ln_rdy,
   output logic          ln_ack
);

   generate
      if (DW < AW) begin : g_bad_dw
         $error("hsk_read_link: DW must be at least AW");
      end
   endgenerate

   logic          ack_dev;
   logic          ack_mem;
   logic [DW-1:0] dev_dq;
   logic [DW-1:0] mem_dq;

   hsk_dev_side #(
      .AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
   ) u_dev (
      .clk    (dev_clk),
      .rst_n  (dev_rst_n),
      .start  (rd_start),
      .addr   (rd_addr),
      .ack_in (ack_mem),
      .rdy_in (ln_rdy),
      .bus_in (bus_data),
      .req    (ln_req),
      .ack_out(ack_dev),
      .oe     (bus_dev_oe),
      .dq     (dev_dq),
      .busy   (rd_busy),
      .done   (rd_done),
      .data   (rd_data)
   );

   hsk_mem_side #(
      .AW(AW), .DW(DW), .MEM_LAT(MEM_LAT), .SYNC_STAGES(SYNC_STAGES),
      .CONTENT_MUL(CONTENT_MUL), .CONTENT_ADD(CONTENT_ADD)
   ) u_mem (
      .clk    (mem_clk),
      .rst_n  (mem_rst_n),
      .req_in (ln_req),
      .ack_in (ack_dev),
      .bus_in (bus_data),
      .ack_out(ack_mem),
      .rdy    (ln_rdy),
      .oe     (bus_mem_oe),
      .dq     (mem_dq)
   );

   always_comb begin
      if (bus_dev_oe)      bus_data = dev_dq;
      else if (bus_mem_oe) bus_data = mem_dq;
      else                 bus_data = '0;
   end

   assign ln_ack = ack_dev | ack_mem;

   a_r9_one_driver_dev: assert property (@(posedge dev_clk)
      disable iff (!dev_rst_n || !mem_rst_n) !(bus_dev_oe && bus_mem_oe));
   a_r9_one_driver_mem: assert property (@(posedge mem_clk)
      disable iff (!dev_rst_n || !mem_rst_n) !(bus_dev_oe && bus_mem_oe));
   a_r5_rdy_not_with_req: assert property (@(posedge mem_clk)
      disable iff (!dev_rst_n || !mem_rst_n) !(ln_rdy && ln_req));

endmodule

// File: tb/hsk_read_link_test.sv
module hsk_read_link_test;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_HALF   = 7;
   localparam int AW         = 4;
   localparam int DW         = 16;
   localparam int NVEC       = 8;
   localparam int TIMEOUT    = 400;
   localparam logic [AW-1:0] VEC_ADDR [NVEC] =
      '{4'd0, 4'd15, 4'd1, 4'd7, 4'd8, 4'd3, 4'd14, 4'd10};

   logic          dev_clk = 1'b0;
   logic          mem_clk = 1'b0;
   logic          dev_rst_n = 1'b0;
   logic          mem_rst_n = 1'b0;
   logic          rd_start = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_busy, rd_done;
   logic [DW-1:0] rd_data, bus_data;
   logic          bus_dev_oe, bus_mem_oe, ln_req, ln_rdy, ln_ack;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int v_r4 = 0, v_r5 = 0, v_r9 = 0;
   logic prev_req = 1'b0, prev_ack = 1'b0, prev_rdy = 1'b0;
   logic mon_on = 1'b0;

   always #(CLK_PERIOD/2) dev_clk = ~dev_clk;
   initial begin
      #1;
      forever #(MEM_HALF) mem_clk = ~mem_clk;
   end

   hsk_read_link #(.AW(AW), .DW(DW)) uut (
      .dev_clk(dev_clk), .dev_rst_n(dev_rst_n),
      .mem_clk(mem_clk), .mem_rst_n(mem_rst_n),
      .rd_start(rd_start), .rd_addr(rd_addr),
      .rd_busy(rd_busy), .rd_done(rd_done), .rd_data(rd_data),
      .bus_data(bus_data), .bus_dev_oe(bus_dev_oe), .bus_mem_oe(bus_mem_oe),
      .ln_req(ln_req), .ln_rdy(ln_rdy), .ln_ack(ln_ack)
   );

   function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
      logic [31:0] p;
      p = 32'(a) * 32'h9E37 + 32'h5A5A;
      return p[DW-1:0];
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // protocol monitor, sampled at the device clock's falling edge
   always @(negedge dev_clk) begin
      cyc++;
      if (mon_on) begin
         if (bus_dev_oe && bus_mem_oe) v_r9++;
         if (ln_rdy && ln_req) v_r5++;
         if (prev_req && !ln_req && !prev_ack) v_r4++;
         if (prev_rdy && !ln_rdy && !prev_ack) v_r5++;
      end
      prev_req = ln_req;
      prev_ack = ln_ack;
      prev_rdy = ln_rdy;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic tick();
      @(negedge dev_clk);
   endtask

   // Drive a command for one cycle, then check R2 at the next sample.
   task automatic issue(input logic [AW-1:0] a, input bit chk);
      rd_addr  = a;
      rd_start = 1'b1;
      tick();
      rd_start = 1'b0;
      if (chk) begin
         check(ln_req && bus_dev_oe && rd_busy, "R2 req/oe/busy",
               {29'd0, ln_req, bus_dev_oe, rd_busy}, 32'h7);
         check(bus_data == DW'(a), "R2 address on lines", 32'(bus_data), 32'(a));
      end
   endtask

   // Wait for done; returns the number of cycles waited (TIMEOUT = none).
   task automatic wait_done(output int waited);
      waited = 0;
      while (!rd_done && waited < TIMEOUT) begin
         tick();
         waited++;
      end
   endtask

   task automatic run_read(input logic [AW-1:0] a);
      int w;
      issue(a, 1'b1);
      w = 0;
      while (!ln_ack && w < TIMEOUT) begin tick(); w++; end
      while (ln_req && w < TIMEOUT) begin tick(); w++; end
      check(!ln_req && !bus_dev_oe, "R3 release after ack",
            {30'd0, ln_req, bus_dev_oe}, 32'd0);
      wait_done(w);
      check(w < TIMEOUT, "R6 done seen", w, TIMEOUT);
      check(rd_data == expect_word(a), "R7 read word", 32'(rd_data),
            32'(expect_word(a)));
      tick();
      check(!rd_done && !rd_busy, "R6 done one cycle", {30'd0, rd_done, rd_busy}, 0);
   endtask

   initial begin
      int w;
      int extra;
      repeat (3) tick();
      mem_rst_n = 1'b1;
      tick();
      dev_rst_n = 1'b1;
      tick();
      // R1 reset state
      check(!ln_req && !ln_rdy && !ln_ack, "R1 control lines low",
            {29'd0, ln_req, ln_rdy, ln_ack}, 0);
      check(!bus_dev_oe && !bus_mem_oe && bus_data == '0 && !rd_busy,
            "R1 lines idle", {14'd0, bus_data, bus_dev_oe, bus_mem_oe}, 0);
      mon_on = 1'b1;

      // vector table walk: R2, R3, R6, R7
      for (int i = 0; i < NVEC; i++) run_read(VEC_ADDR[i]);

      // back-to-back reads with no gap
      run_read(4'd5);
      run_read(4'd5);

      // R8: second command while busy is ignored
      issue(4'd2, 1'b1);
      repeat (5) tick();
      check(rd_busy, "R8 still busy", 32'(rd_busy), 1);
      issue(4'd11, 1'b0);
      wait_done(w);
      check(w < TIMEOUT, "R8 first done seen", w, TIMEOUT);
      check(rd_data == expect_word(4'd2), "R8 word of first address",
            32'(rd_data), 32'(expect_word(4'd2)));
      extra = 0;
      for (int k = 0; k < 150; k++) begin
         tick();
         if (rd_done) extra++;
      end
      check(extra == 0, "R8 no second done", extra, 0);
      check(!rd_busy && !ln_req, "R8 idle afterwards", {30'd0, rd_busy, ln_req}, 0);

      // interlock monitors
      check(v_r4 == 0, "R4 request held until ack", v_r4, 0);
      check(v_r5 == 0, "R5 data-ready ordering", v_r5, 0);
      check(v_r9 == 0, "R9 single driver", v_r9, 0);
      finish_run();
   end

endmodule